// File: doc/BRIEF.md
# Floppy Drive Output Control Register

This block is the host-visible byte that steers a two-drive floppy disk interface. Software writes one byte at I/O address 0x3F2 to choose a drive, switch spindle motors, enable or block DMA and interrupt requests, and hold the disk controller core in a software reset. The same byte reads back unchanged at any time. That includes the time when the byte itself is holding the core in reset.

The drive-select outputs are decoded from the two select bits together with the matching motor bit, so a drive is selected only while its motor is on. A finite-state machine with the states HELD, STRETCH and RUN turns the reset bit into the core reset output.
- **HELD to STRETCH**: taken when the reset bit reads 1.
- **STRETCH to RUN**: taken after a parameter-derived number of cycles, which covers at least 100 ns.
- **STRETCH to HELD** and **RUN to HELD**: taken whenever the reset bit reads 0.

The DMA and interrupt requests from the core pass through a gate. The gate depends on the DMA-enable bit in the AT / Model-30 mode and is always open in the PS/2 mode.

Top module: `fdc_outctl`

## Requirements
- R1: A write (host_wr high at a clock edge) changes the register only when host_addr equals 0x3F2. A write to any other address leaves the register and every output unchanged. host_rdata returns 0x00 whenever host_addr is not 0x3F2.
- R2: While host_addr is 0x3F2, host_rdata shows all 8 stored bits exactly as written, from the cycle after the write. This holds while core_rst is high as well.
- R3: The bit layout is: bits 1:0 select the drive, bit 2 is the active-low reset request, bit 3 is DMA enable, and bits 7:4 are motor enables 3..0. drv_sel_n[0] is low only for select 00 with bit 4 set. drv_sel_n[1] is low only for select 01 with bit 5 set. Otherwise both are high, and at most one is ever low. Two examples: 0x1C gives drv_sel_n = 2'b10, and 0x2D gives 2'b01.
- R4: mtr_on_n[0] is the inverse of bit 4 and mtr_on_n[1] is the inverse of bit 5. Bits 6 and 7 affect no output.
- R5: When bit 2 is 0, core_rst is high from the second clock edge after the write that cleared the bit. It stays high for as long as bit 2 stays 0.
- R6: After a write sets bit 2 to 1, core_rst stays high until the STRETCH_CYC+1-th edge after that write and then falls. STRETCH_CYC = ceil(MIN_SRST_PS / CLK_PERIOD_PS), and is 20 by default.
- R7: The software reset changes no register bit. The byte reads back and drives its outputs unchanged while core_rst is high.
- R8: With mode_ps2 = 0, dma_req_o = dma_req_i AND bit 3, and irq_o = irq_i AND bit 3.
- R9: With mode_ps2 = 1, dma_req_o = dma_req_i and irq_o = irq_i, whatever the value of bit 3.
- R10: A hardware reset (hw_rst high at an edge) clears the register to 0x00. After it, core_rst is high, both drive selects and both motor outputs are high, and the requests are blocked in AT mode.
- R11: Writing bit 2 as 0 and then as 1 on two consecutive cycles produces a core_rst pulse that lasts at least STRETCH_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst | input | 1 | Synchronous hardware reset, active high |
| host_addr | input | ADDR_W (16) | Host I/O address |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational on host_addr) |
| mode_ps2 | input | 1 | 1 = PS/2 mode, 0 = AT / Model-30 mode |
| dma_req_i | input | 1 | DMA request from the controller core |
| irq_i | input | 1 | Interrupt request from the controller core |
| drv_sel_n | output | NUM_DRV (2) | Drive select, active low |
| mtr_on_n | output | NUM_DRV (2) | Motor on, active low |
| core_rst | output | 1 | Held software reset to the controller core |
| dma_req_o | output | 1 | Gated DMA request |
| irq_o | output | 1 | Gated interrupt request |

## Verification
The hardest case to reach from the ports is a reset bit that reads 0 for exactly one cycle, which is the valid 0-then-1 write pair. The FSM must still catch that single cycle, leave RUN, and then run the full stretch. The stimulus issues the two writes on consecutive edges with no idle cycle between them. The scoreboard then expects core_rst high at the first edge after the pair and still high STRETCH_CYC edges later, and low one edge after that. A separate case reopens the stretch from the HELD state.

// File: rtl/fdc_outctl_pkg.sv
package fdc_outctl_pkg;

    typedef enum logic [1:0] {
        RS_HELD    = 2'd0,
        RS_STRETCH = 2'd1,
        RS_RUN     = 2'd2
    } srst_state_t;

    localparam int SEL_LSB   = 0;
    localparam int SEL_W     = 2;
    localparam int SRST_BIT  = 2;
    localparam int DMAEN_BIT = 3;
    localparam int MOT_LSB   = 4;

    function automatic int stretch_cycles(input int min_ps, input int clk_ps);
        int c;
        c = (min_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/fdc_outctl_regs.sv
module fdc_outctl_regs #(
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] REG_ADDR = 16'h03F2
) (
    input  logic              clk,
    input  logic              hw_rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        ctl_q,
    output logic [7:0]        host_rdata
);
    localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(REG_ADDR);

    logic hit;

    always_comb hit = (host_addr == MATCH);

    always_ff @(posedge clk) begin
        if (hw_rst) begin
            ctl_q <= 8'h00;
        end else if (host_wr && hit) begin
            ctl_q <= host_wdata;
        end
    end

    always_comb host_rdata = hit ? ctl_q : 8'h00;

    p_write_lands_r1: assert property (@(posedge clk) disable iff (hw_rst)
        (host_wr && hit) |=> (ctl_q == $past(host_wdata)));

    p_miss_ignored_r1: assert property (@(posedge clk) disable iff (hw_rst)
        !(host_wr && hit) |=> $stable(ctl_q));

endmodule

// File: rtl/fdc_outctl_srst.sv
module fdc_outctl_srst
    import fdc_outctl_pkg::*;
#(
    parameter int STRETCH_CYC = 20
) (
    input  logic clk,
    input  logic hw_rst,
    input  logic srst_bit,
    output logic core_rst
);
    localparam int CW = $clog2(STRETCH_CYC) + 1;
    localparam logic [CW-1:0] LAST = CW'(STRETCH_CYC - 1);

    srst_state_t     state, nxt;
    logic [CW-1:0]   cnt, cnt_nxt;

    always_ff @(posedge clk) begin
        if (hw_rst) begin
            state <= RS_HELD;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        unique case (state)
            RS_HELD: begin
                if (srst_bit) begin
                    nxt     = RS_STRETCH;
                    cnt_nxt = '0;
                end
            end
            RS_STRETCH: begin
                if (!srst_bit) begin
                    nxt = RS_HELD;
                end else if (cnt == LAST) begin
                    nxt = RS_RUN;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            RS_RUN: begin
                if (!srst_bit) nxt = RS_HELD;
            end
            default: nxt = RS_HELD;
        endcase
    end

    always_comb core_rst = (state != RS_RUN);

    int hi_run;
    always_ff @(posedge clk) begin
        if (hw_rst) hi_run <= 0;
        else if (core_rst) hi_run <= (hi_run < STRETCH_CYC + 4) ? hi_run + 1 : hi_run;
        else hi_run <= 0;
    end

    p_held_r5: assert property (@(posedge clk) disable iff (hw_rst)
        !srst_bit |=> core_rst);

    p_release_needs_bit_r6: assert property (@(posedge clk) disable iff (hw_rst)
        $fell(core_rst) |-> ($past(srst_bit) && srst_bit));

    p_min_width_r11: assert property (@(posedge clk) disable iff (hw_rst)
        $fell(core_rst) |-> (hi_run >= STRETCH_CYC));

    p_run_stays_r6: assert property (@(posedge clk) disable iff (hw_rst)
        (!core_rst && srst_bit) |=> !core_rst);

endmodule

// File: rtl/fdc_outctl_decode.sv
module fdc_outctl_decode
    import fdc_outctl_pkg::*;
#(
    parameter int NUM_DRV = 2
) (
    input  logic [7:0]         ctl,
    input  logic               mode_ps2,
    input  logic               dma_req_i,
    input  logic               irq_i,
    output logic [NUM_DRV-1:0] drv_sel_n,
    output logic [NUM_DRV-1:0] mtr_on_n,
    output logic               dma_req_o,
    output logic               irq_o
);
    logic [SEL_W-1:0] sel;
    logic             gate_open;

    always_comb sel = ctl[SEL_LSB +: SEL_W];

    for (genvar d = 0; d < NUM_DRV; d++) begin : g_drv
        always_comb begin
            mtr_on_n[d]  = ~ctl[MOT_LSB + d];
            drv_sel_n[d] = ~((sel == SEL_W'(d)) && ctl[MOT_LSB + d]);
        end
    end

    always_comb begin
        gate_open = mode_ps2 || ctl[DMAEN_BIT];
        dma_req_o = dma_req_i && gate_open;
        irq_o     = irq_i && gate_open;
    end

endmodule

// File: rtl/fdc_outctl.sv
module fdc_outctl
    import fdc_outctl_pkg::*;
#(
    parameter int          ADDR_W        = 16,
    parameter logic [15:0] REG_ADDR      = 16'h03F2,
    parameter int          NUM_DRV       = 2,
    parameter int          CLK_PERIOD_PS = 5000,
    parameter int          MIN_SRST_PS   = 100000
) (
    input  logic               clk,
    input  logic               hw_rst,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic               host_wr,
    input  logic [7:0]         host_wdata,
    output logic [7:0]         host_rdata,
    input  logic               mode_ps2,
    input  logic               dma_req_i,
    input  logic               irq_i,
    output logic [NUM_DRV-1:0] drv_sel_n,
    output logic [NUM_DRV-1:0] mtr_on_n,
    output logic               core_rst,
    output logic               dma_req_o,
    output logic               irq_o
);
    localparam int STRETCH_CYC = stretch_cycles(MIN_SRST_PS, CLK_PERIOD_PS);

    logic [7:0] ctl_q;

    fdc_outctl_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
        .clk        (clk),
        .hw_rst     (hw_rst),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .ctl_q      (ctl_q),
        .host_rdata (host_rdata)
    );

    fdc_outctl_srst #(.STRETCH_CYC(STRETCH_CYC)) u_srst (
        .clk      (clk),
        .hw_rst   (hw_rst),
        .srst_bit (ctl_q[SRST_BIT]),
        .core_rst (core_rst)
    );

    fdc_outctl_decode #(.NUM_DRV(NUM_DRV)) u_dec (
        .ctl       (ctl_q),
        .mode_ps2  (mode_ps2),
        .dma_req_i (dma_req_i),
        .irq_i     (irq_i),
        .drv_sel_n (drv_sel_n),
        .mtr_on_n  (mtr_on_n),
        .dma_req_o (dma_req_o),
        .irq_o     (irq_o)
    );

    p_one_sel_r3: assert property (@(posedge clk) disable iff (hw_rst)
        $countones(~drv_sel_n) <= 1);

    p_sel_needs_motor_r3: assert property (@(posedge clk) disable iff (hw_rst)
        !drv_sel_n[0] |-> !mtr_on_n[0]);

    p_at_blocked_r8: assert property (@(posedge clk) disable iff (hw_rst)
        (!mode_ps2 && !ctl_q[DMAEN_BIT]) |-> (!dma_req_o && !irq_o));

    p_ps2_open_r9: assert property (@(posedge clk) disable iff (hw_rst)
        mode_ps2 |-> ((dma_req_o == dma_req_i) && (irq_o == irq_i)));

endmodule

// File: tb/fdc_outctl_bench.sv
`timescale 1ns/1ps
module fdc_outctl_bench;
    localparam int S = 20;
    localparam logic [15:0] A_REG = 16'h03F2;

    logic        clk = 1'b0;
    logic        hw_rst = 1'b1;
    logic [15:0] host_addr = A_REG;
    logic        host_wr = 1'b0;
    logic [7:0]  host_wdata = 8'h00;
    logic [7:0]  host_rdata;
    logic        mode_ps2 = 1'b0;
    logic        dma_req_i = 1'b1;
    logic        irq_i = 1'b1;
    logic [1:0]  drv_sel_n, mtr_on_n;
    logic        core_rst, dma_req_o, irq_o;

    fdc_outctl u_fdc_outctl (
        .clk(clk), .hw_rst(hw_rst), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mode_ps2(mode_ps2),
        .dma_req_i(dma_req_i), .irq_i(irq_i), .drv_sel_n(drv_sel_n),
        .mtr_on_n(mtr_on_n), .core_rst(core_rst), .dma_req_o(dma_req_o), .irq_o(irq_o)
    );

    always #2.5 clk = ~clk;

    typedef enum int {F_RD, F_SEL, F_MTR, F_RST, F_DMA, F_IRQ} fld_t;
    typedef struct {
        int        due;
        fld_t      fld;
        logic [7:0] val;
        string     req;
    } exp_t;

    exp_t q[$];
    int cyc = 0;
    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] actual(fld_t f);
        case (f)
            F_RD:    return host_rdata;
            F_SEL:   return {6'd0, drv_sel_n};
            F_MTR:   return {6'd0, mtr_on_n};
            F_RST:   return {7'd0, core_rst};
            F_DMA:   return {7'd0, dma_req_o};
            default: return {7'd0, irq_o};
        endcase
    endfunction

    // monitor: pop due items and compare mid-cycle
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t it;
            logic [7:0] a;
            it = q.pop_front();
            a = actual(it.fld);
            compared++;
            if (it.due < cyc || a !== it.val) begin
                mismatched++;
                $display("FAIL %s field=%0d cyc=%0d actual=%02h expected=%02h",
                         it.req, it.fld, cyc, a, it.val);
            end
        end
    end

    task automatic push(int delta, fld_t f, logic [7:0] v, string req);
        exp_t e;
        e.due = cyc + delta; e.fld = f; e.val = v; e.req = req;
        q.push_back(e);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        @(posedge clk); #1;
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(posedge clk); #1;
        host_wr = 1'b0; host_addr = A_REG;
    endtask

    task automatic wr_pair(logic [7:0] d0, logic [7:0] d1);
        @(posedge clk); #1;
        host_addr = A_REG; host_wdata = d0; host_wr = 1'b1;
        @(posedge clk); #1;
        host_wdata = d1;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic outs(logic [7:0] rd, logic [1:0] sel, logic [1:0] mtr, string req);
        push(0, F_RD, rd, req);
        push(0, F_SEL, {6'd0, sel}, req);
        push(0, F_MTR, {6'd0, mtr}, req);
    endtask

    initial begin
        idle(3);
        // R10: reset state
        push(0, F_RD, 8'h00, "R10");
        push(0, F_SEL, 8'h03, "R10");
        push(0, F_MTR, 8'h03, "R10");
        push(0, F_RST, 8'h01, "R10");
        push(0, F_DMA, 8'h00, "R10");
        hw_rst = 1'b0;
        idle(2);
        push(0, F_RD, 8'h00, "R10");
        push(0, F_RST, 8'h01, "R10");

        // R3/R4/R2: drive 0, then stretch R6
        wr(A_REG, 8'h1C);
        outs(8'h1C, 2'b10, 2'b10, "R3");
        push(0, F_DMA, 8'h01, "R8");
        push(S, F_RST, 8'h01, "R6");
        push(S + 1, F_RST, 8'h00, "R6");
        idle(S + 3);

        wr(A_REG, 8'h2D);
        outs(8'h2D, 2'b01, 2'b01, "R3");
        wr(A_REG, 8'h3C);
        outs(8'h3C, 2'b10, 2'b00, "R4");
        wr(A_REG, 8'h2C);
        outs(8'h2C, 2'b11, 2'b01, "R3");
        wr(A_REG, 8'hFF);
        outs(8'hFF, 2'b11, 2'b00, "R2");
        wr(A_REG, 8'hC4);
        outs(8'hC4, 2'b11, 2'b11, "R4");
        push(0, F_DMA, 8'h00, "R8");
        push(0, F_IRQ, 8'h00, "R8");
        idle(1);
        mode_ps2 = 1'b1;
        push(0, F_DMA, 8'h01, "R9");
        push(0, F_IRQ, 8'h01, "R9");
        idle(1);
        irq_i = 1'b0;
        push(0, F_IRQ, 8'h00, "R9");
        idle(1);
        mode_ps2 = 1'b0; irq_i = 1'b1;
        wr(A_REG, 8'h2D);
        dma_req_i = 1'b0;
        push(0, F_DMA, 8'h00, "R8");
        push(0, F_IRQ, 8'h01, "R8");
        idle(1);
        dma_req_i = 1'b1;

        // R1: other address ignored
        wr(16'h03F3, 8'h00);
        outs(8'h2D, 2'b01, 2'b01, "R1");
        push(0, F_RST, 8'h00, "R1");
        idle(1);
        host_addr = 16'h03F3;
        push(0, F_RD, 8'h00, "R1");
        idle(1);
        host_addr = A_REG;

        // R5/R7: hold reset
        wr(A_REG, 8'h18);
        push(0, F_RST, 8'h00, "R5");
        push(1, F_RST, 8'h01, "R5");
        idle(4);
        outs(8'h18, 2'b10, 2'b10, "R7");
        push(0, F_RST, 8'h01, "R5");
        idle(2);
        wr(A_REG, 8'h1C);
        push(0, F_RD, 8'h1C, "R2");
        push(S, F_RST, 8'h01, "R6");
        push(S + 1, F_RST, 8'h00, "R6");
        idle(S + 3);

        // R11: back-to-back 0 then 1
        wr_pair(8'h18, 8'h1C);
        push(0, F_RST, 8'h01, "R11");
        push(S, F_RST, 8'h01, "R11");
        push(S + 1, F_RST, 8'h00, "R11");
        idle(S + 3);

        // R10: hardware reset mid-operation
        wr(A_REG, 8'hFD);
        mode_ps2 = 1'b0;
        hw_rst = 1'b1;
        idle(2);
        hw_rst = 1'b0;
        outs(8'h00, 2'b11, 2'b11, "R10");
        push(0, F_RST, 8'h01, "R10");
        push(0, F_DMA, 8'h00, "R10");
        idle(3);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule